// File: doc/BRIEF.md
# Camera isochronous packet deframer

This block sits behind a camera bridge's isochronous endpoint and turns a stream of bytes, delimited into packets by start and end markers, into frame-delimited image payload. Each packet opens with two header bytes. The low six bits of the first byte hold a sequence code. The top two bits of the first byte and the whole second byte together form a 10-bit payload length. When the sequence code is all ones, the packet starts a frame. That packet has a 30-byte header, and header bytes 2 to 5 carry colour statistics. Every other packet has an 8-byte header.

The block drops the header and forwards exactly the declared number of payload bytes, each one cycle after it arrives. It reports the opening of a frame, and it reports the closing of the previous frame with an error flag. A frame is flagged as bad if any of these happened while it was open: a zero-length ordinary packet, bytes beyond the declared length, or a packet that ended inside its header. The statistics bytes are latched with a valid pulse. Downstream logic assembles the frames and decides whether to keep or discard each one.

Top module: `isoc_deframe`

## Requirements
- R1: After reset, all pulse outputs (`pay_valid_o`, `frm_start_o`, `frm_end_o`, `frm_err_o`, `drop_o`, `stat_valid_o`) are low.
- R2: A packet whose first byte has bits [5:0] equal to 6'h3F is a frame-start packet. `frm_start_o` pulses one cycle after that packet's second byte.
- R3: The payload length is {byte0[7:6], byte1[7:0]}. Exactly that many bytes are forwarded, with no adjustment, including lengths at or above 256.
- R4: Payload begins at byte offset 30 in a frame-start packet and at byte offset 8 in any other packet. Header bytes are never forwarded.
- R5: In a frame-start packet, bytes 2, 3, 4 and 5 appear on `stat_g0_o`, `stat_r_o`, `stat_g1_o` and `stat_b_o`. `stat_valid_o` pulses one cycle after byte 5.
- R6: An ordinary packet with length zero pulses `drop_o` one cycle after its second byte, forwards nothing, and marks the open frame bad.
- R7: Bytes past the declared length are not forwarded and mark the frame bad.
- R8: A packet whose end marker arrives before its header is complete marks the frame bad. If the packet is a frame-start packet that reached its second byte, the newly opened frame is the one marked bad.
- R9: A frame-start packet closes the open frame: `frm_end_o` pulses in the same cycle as `frm_start_o`, and `frm_err_o` is high with it exactly when that frame was marked bad. The first frame-start after reset produces no `frm_end_o`.
- R10: Payload of packets that arrive before the first frame-start is not forwarded.
- R11: Bytes with `in_valid_i` high that arrive between a packet's end and the next start marker are ignored.
- R12: A forwarded byte appears on `pay_data_o` with `pay_valid_o` exactly one cycle after it was accepted at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_sop_i | input | 1 | Byte is the first of a packet |
| in_eop_i | input | 1 | Byte is the last of a packet |
| pay_valid_o | output | 1 | Payload byte valid |
| pay_data_o | output | 8 | Payload byte |
| frm_start_o | output | 1 | Frame opened |
| frm_end_o | output | 1 | Previous frame closed |
| frm_err_o | output | 1 | Closed frame is bad (valid with frm_end_o) |
| drop_o | output | 1 | Zero-length packet discarded |
| stat_valid_o | output | 1 | Statistics registers updated |
| stat_g0_o | output | 8 | First green statistic |
| stat_r_o | output | 8 | Red statistic |
| stat_g1_o | output | 8 | Second green statistic |
| stat_b_o | output | 8 | Blue statistic |

## Verification
The assertions check these properties on every cycle:
- A frame end never appears without a coinciding frame start.
- An error never appears without an end.
- Payload never coincides with a header-time event.
- Payload always mirrors the previous cycle's input byte.
- Neither payload nor statistics appear before the first frame opens.

Only the bench's scenarios can show the following:
- Whether the payload count matches the 10-bit length and the header offsets.
- Whether the error flag attaches to the right frame after excess bytes, zero-length packets or truncated headers.
- Whether the statistics bytes land in the right registers.

// File: rtl/isoc_deframe_pkg.sv
package isoc_deframe_pkg;
  typedef logic [7:0] byte_t;

  // per-beat classification from header tracker to frame control
  typedef struct packed {
    logic pay;
    logic excess;
    logic trunc;
    logic zero;
    logic fs_ev;
    logic stat_we;
    logic stat_done;
  } beat_cls_t;
endpackage

// File: rtl/isoc_hdr_track.sv
module isoc_hdr_track
  import isoc_deframe_pkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int SEQ_W   = 6,
  parameter int FS_HDR  = 30,
  parameter int STD_HDR = 8,
  parameter int FS_CODE = 'h3F,
  parameter int IDX_W   = 11
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      valid_i,
  input  byte_t     data_i,
  input  logic      sop_i,
  input  logic      eop_i,
  output beat_cls_t cls_o,
  output logic [1:0] stat_sel_o
);
  localparam int HI_W = LEN_W - 8;
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic              in_pkt_q, fs_q;
  logic [IDX_W-1:0]  idx_q, cur_idx, hdr_len, pay_end;
  logic [HI_W-1:0]   len_hi_q;
  logic [LEN_W-1:0]  len_q, len_cur;
  logic              beat, first, second, fs_byte0, fs_cur, in_hdr;

  always_comb begin
    beat     = valid_i && (sop_i || in_pkt_q);
    cur_idx  = sop_i ? '0 : idx_q;
    first    = (cur_idx == '0);
    second   = (cur_idx == IDX_W'(1));
    fs_byte0 = (data_i[SEQ_W-1:0] == SEQ_W'(FS_CODE));
    fs_cur   = first ? fs_byte0 : fs_q;
    hdr_len  = fs_cur ? IDX_W'(FS_HDR) : IDX_W'(STD_HDR);
    len_cur  = second ? {len_hi_q, data_i} : len_q;
    pay_end  = hdr_len + IDX_W'(len_cur);
    in_hdr   = cur_idx < hdr_len;

    cls_o.pay       = beat && !in_hdr && (cur_idx < pay_end);
    cls_o.excess    = beat && !in_hdr && (cur_idx >= pay_end);
    cls_o.trunc     = beat && eop_i && (cur_idx < hdr_len - IDX_W'(1));
    cls_o.fs_ev     = beat && second && fs_q;
    cls_o.zero      = beat && second && !fs_q && (len_cur == '0);
    cls_o.stat_we   = beat && fs_cur && (cur_idx >= IDX_W'(2)) && (cur_idx <= IDX_W'(5));
    cls_o.stat_done = beat && fs_cur && (cur_idx == IDX_W'(5));
    stat_sel_o      = cur_idx[1:0] + 2'd2;  // byte 2..5 -> slot 0..3
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt_q <= 1'b0;
      idx_q    <= '0;
      fs_q     <= 1'b0;
      len_hi_q <= '0;
      len_q    <= '0;
    end else if (beat) begin
      in_pkt_q <= !eop_i;
      idx_q    <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + IDX_W'(1);
      if (first) begin
        fs_q     <= fs_byte0;
        len_hi_q <= data_i[7 -: HI_W];
      end
      if (second) len_q <= len_cur;
    end
  end
endmodule

// File: rtl/isoc_frame_ctl.sv
module isoc_frame_ctl
  import isoc_deframe_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  beat_cls_t cls_i,
  input  byte_t     data_i,
  output logic      pay_valid_o,
  output byte_t     pay_data_o,
  output logic      frm_start_o,
  output logic      frm_end_o,
  output logic      frm_err_o,
  output logic      drop_o
);
  logic open_q, bad_q, err_now;

  assign err_now = cls_i.excess || cls_i.trunc || cls_i.zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q      <= 1'b0;
      bad_q       <= 1'b0;
      pay_valid_o <= 1'b0;
      pay_data_o  <= '0;
      frm_start_o <= 1'b0;
      frm_end_o   <= 1'b0;
      frm_err_o   <= 1'b0;
      drop_o      <= 1'b0;
    end else begin
      pay_valid_o <= cls_i.pay && open_q;
      pay_data_o  <= data_i;
      frm_start_o <= cls_i.fs_ev;
      frm_end_o   <= cls_i.fs_ev && open_q;
      frm_err_o   <= cls_i.fs_ev && open_q && bad_q;
      drop_o      <= cls_i.zero;
      if (cls_i.fs_ev) begin
        open_q <= 1'b1;
        bad_q  <= err_now;  // error on the same beat belongs to the new frame
      end else if (err_now) begin
        bad_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/isoc_stat_latch.sv
module isoc_stat_latch
  import isoc_deframe_pkg::*;
#(
  parameter int N_STAT = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic                  done_i,
  input  logic [$clog2(N_STAT)-1:0] sel_i,
  input  byte_t                 data_i,
  output logic [N_STAT-1:0][7:0] stat_o,
  output logic                  valid_o
);
  for (genvar g = 0; g < N_STAT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_o[g] <= '0;
      else if (we_i && sel_i == g) stat_o[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= done_i;
  end
endmodule

// File: rtl/isoc_deframe.sv
module isoc_deframe
  import isoc_deframe_pkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int SEQ_W   = 6,
  parameter int FS_HDR  = 30,
  parameter int STD_HDR = 8,
  parameter int FS_CODE = 'h3F
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_sop_i,
  input  logic       in_eop_i,
  output logic       pay_valid_o,
  output logic [7:0] pay_data_o,
  output logic       frm_start_o,
  output logic       frm_end_o,
  output logic       frm_err_o,
  output logic       drop_o,
  output logic       stat_valid_o,
  output logic [7:0] stat_g0_o,
  output logic [7:0] stat_r_o,
  output logic [7:0] stat_g1_o,
  output logic [7:0] stat_b_o
);
  localparam int IDX_W  = $clog2(FS_HDR + (1 << LEN_W));
  localparam int N_STAT = 4;

  beat_cls_t             cls;
  logic [1:0]            stat_sel;
  logic [N_STAT-1:0][7:0] stat;

  isoc_hdr_track #(
    .LEN_W(LEN_W), .SEQ_W(SEQ_W), .FS_HDR(FS_HDR),
    .STD_HDR(STD_HDR), .FS_CODE(FS_CODE), .IDX_W(IDX_W)
  ) u_hdr (
    .clk_i, .rst_ni,
    .valid_i(in_valid_i), .data_i(in_data_i),
    .sop_i(in_sop_i), .eop_i(in_eop_i),
    .cls_o(cls), .stat_sel_o(stat_sel)
  );

  isoc_frame_ctl u_frm (
    .clk_i, .rst_ni,
    .cls_i(cls), .data_i(in_data_i),
    .pay_valid_o, .pay_data_o,
    .frm_start_o, .frm_end_o, .frm_err_o, .drop_o
  );

  isoc_stat_latch #(.N_STAT(N_STAT)) u_stat (
    .clk_i, .rst_ni,
    .we_i(cls.stat_we), .done_i(cls.stat_done),
    .sel_i(stat_sel), .data_i(in_data_i),
    .stat_o(stat), .valid_o(stat_valid_o)
  );

  assign stat_g0_o = stat[0];
  assign stat_r_o  = stat[1];
  assign stat_g1_o = stat[2];
  assign stat_b_o  = stat[3];
endmodule

// File: rtl/isoc_deframe_chk.sv
module isoc_deframe_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic [7:0] in_data_i,
  input logic       pay_valid_o,
  input logic [7:0] pay_data_o,
  input logic       frm_start_o,
  input logic       frm_end_o,
  input logic       frm_err_o,
  input logic       drop_o,
  input logic       stat_valid_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          seen_q <= 1'b0;
    else if (frm_start_o) seen_q <= 1'b1;
  end

  AST_END_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_end_o |-> frm_start_o); // R9
  AST_ERR_ON_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_err_o |-> frm_end_o); // R9
  AST_PAY_NOT_HDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> (!frm_start_o && !drop_o)); // R4
  AST_PAY_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> ($past(in_valid_i) && pay_data_o == $past(in_data_i))); // R12
  AST_PAY_AFTER_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> seen_q); // R10
  AST_DROP_NOT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> !frm_start_o); // R6
  AST_STAT_AFTER_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> seen_q); // R5
endmodule

bind isoc_deframe isoc_deframe_chk u_chk (.*);

// File: tb/isoc_deframe_tb.sv
module isoc_deframe_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = '0;
  logic pay_valid, frm_start, frm_end, frm_err, drop, stat_valid;
  logic [7:0] pay_data, s_g0, s_r, s_g1, s_b;

  always #5 clk = ~clk;

  isoc_deframe u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .pay_valid_o(pay_valid), .pay_data_o(pay_data),
    .frm_start_o(frm_start), .frm_end_o(frm_end), .frm_err_o(frm_err), .drop_o(drop),
    .stat_valid_o(stat_valid), .stat_g0_o(s_g0), .stat_r_o(s_r), .stat_g1_o(s_g1), .stat_b_o(s_b)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // observed
  logic [7:0] got_pay[$];
  bit         got_end[$];
  int got_start = 0, got_drop = 0, got_stat = 0;
  logic [7:0] got_sv[4];
  // model
  logic [7:0] exp_pay[$];
  bit         exp_end[$];
  int exp_start = 0, exp_drop = 0, exp_stat = 0;
  logic [7:0] exp_sv[4];
  bit m_open = 0, m_bad = 0;
  logic [7:0] last_b;

  always @(negedge clk) if (rst_n) begin
    if (pay_valid) got_pay.push_back(pay_data);
    if (frm_end)   got_end.push_back(frm_err);
    if (frm_start) got_start++;
    if (drop)      got_drop++;
    if (stat_valid) begin
      got_stat++;
      got_sv[0] = s_g0; got_sv[1] = s_r; got_sv[2] = s_g1; got_sv[3] = s_b;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] d, input bit s, input bit e);
    @(posedge clk); #1;
    in_valid = 1; in_data = d; in_sop = s; in_eop = e;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  // model from requirements: R2..R10
  task automatic send_pkt(input logic [5:0] seq, input logic [9:0] len, input int total);
    int hdr;
    logic [7:0] b;
    bit fs;
    fs  = (seq == 6'h3F);
    hdr = fs ? 30 : 8;
    for (int i = 0; i < total; i++) begin
      if (i == 0)      b = {len[9:8], seq};
      else if (i == 1) b = len[7:0];
      else             b = 8'($urandom);
      if (i == 1 && fs) begin
        if (m_open) exp_end.push_back(m_bad);
        m_open = 1; m_bad = 0; exp_start++;
      end
      if (i == 1 && !fs && len == 0) begin exp_drop++; m_bad = 1; end
      if (i >= hdr) begin
        if (i < hdr + int'(len)) begin if (m_open) exp_pay.push_back(b); end
        else m_bad = 1;
      end
      if (fs && i >= 2 && i <= 5) begin
        exp_sv[i-2] = b;
        if (i == 5) exp_stat++;
      end
      if (i == total - 1 && total < hdr) m_bad = 1;
      last_b = b;
      put_byte(b, i == 0, i == total - 1);
    end
    idle();
  endtask

  task automatic check_all(input string tag);
    repeat (3) @(negedge clk);
    chk(got_pay.size() == exp_pay.size(), {tag, " R3 R4 R10 payload count"}, got_pay.size(), exp_pay.size());
    for (int i = 0; i < exp_pay.size() && i < got_pay.size(); i++)
      chk(got_pay[i] === exp_pay[i], {tag, " R3 payload byte"}, got_pay[i], exp_pay[i]);
    chk(got_end.size() == exp_end.size(), {tag, " R9 end count"}, got_end.size(), exp_end.size());
    for (int i = 0; i < exp_end.size() && i < got_end.size(); i++)
      chk(got_end[i] == exp_end[i], {tag, " R7 R8 R9 end error flag"}, got_end[i], exp_end[i]);
    chk(got_start == exp_start, {tag, " R2 start count"}, got_start, exp_start);
    chk(got_drop == exp_drop, {tag, " R6 drop count"}, got_drop, exp_drop);
    chk(got_stat == exp_stat, {tag, " R5 stat count"}, got_stat, exp_stat);
    if (exp_stat > 0)
      for (int k = 0; k < 4; k++)
        chk(got_sv[k] === exp_sv[k], {tag, " R5 stat value"}, got_sv[k], exp_sv[k]);
    got_pay.delete(); exp_pay.delete(); got_end.delete(); exp_end.delete();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(!(pay_valid|frm_start|frm_end|frm_err|drop|stat_valid), "R1 reset outputs", 1, 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // R10: ordinary payload before any frame
    send_pkt(6'h01, 10'd5, 13);
    check_all("R10");

    // R2 R5 first frame, no end yet
    send_pkt(6'h3F, 10'd4, 34);
    send_pkt(6'h02, 10'd3, 11);
    check_all("R2");

    // R12 directed latency on a 1-byte payload
    send_pkt(6'h3F, 10'd1, 31);
    @(negedge clk);
    chk(pay_valid === 1'b1 && pay_data === last_b, "R12 payload one cycle after input", pay_data, last_b);
    @(negedge clk);
    chk(pay_valid === 1'b0, "R12 single payload pulse", pay_valid, 0);
    check_all("R12");

    // R3 long length with upper bits set
    send_pkt(6'h05, 10'h105, 8 + 'h105);
    send_pkt(6'h3F, 10'd0, 30);
    check_all("R3");

    // R6 zero-length ordinary
    send_pkt(6'h06, 10'd0, 8);
    send_pkt(6'h3F, 10'd2, 32);
    check_all("R6");

    // R7 excess bytes
    send_pkt(6'h07, 10'd3, 14);
    send_pkt(6'h3F, 10'd2, 32);
    check_all("R7");

    // R8 truncated ordinary header, then truncated frame-start header
    send_pkt(6'h08, 10'd4, 5);
    send_pkt(6'h3F, 10'd2, 10);
    send_pkt(6'h3F, 10'd2, 32);
    check_all("R8");

    // R11 stray bytes between packets
    for (int i = 0; i < 6; i++) put_byte(8'($urandom), 0, 0);
    idle();
    send_pkt(6'h3F, 10'd3, 33);
    check_all("R11");

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [5:0] sq;
      logic [9:0] ln;
      int hdr, tot, r;
      sq  = ($urandom % 6 == 0) ? 6'h3F : 6'($urandom % 63);
      ln  = ($urandom % 5 == 0) ? 10'd0 : 10'($urandom % 40);
      hdr = (sq == 6'h3F) ? 30 : 8;
      r   = $urandom % 8;
      if (r == 0)      tot = 1 + $urandom % (hdr - 1);
      else if (r == 1) tot = hdr + int'(ln) + 1 + $urandom % 3;
      else             tot = hdr + int'(ln);
      send_pkt(sq, ln, tot);
      if ($urandom % 4 == 0) idle();
      if (n % 25 == 24) check_all("R9 random");
    end
    send_pkt(6'h3F, 10'd0, 30);
    check_all("R9 final");

    finish_run();
  end
endmodule